// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker serves one DMA channel. It follows a singly linked chain of buffer descriptors kept in memory. Software places the address of the first descriptor in the head register. The walker then reads the buffer pointer, the length and the flags of the current descriptor over a synchronous memory port. It hands the buffer to a data mover through a request/done handshake and waits for that transfer to finish. When the transfer is done it reads the link word again and writes an updated flags word back to the descriptor. The same engine serves a transmit chain of filled packets and a receive chain of empty buffers.

The link word is read after the transfer completes, so software can append to a running chain by patching the null link of its last descriptor. If the patch arrives too late, the walker has already ended the chain, and an end-of-chain marker in the last packet's flags word records this. Software sees the marker and writes the head register again to resume. Every completed descriptor produces a one-cycle completion pulse with its address. Completion-pointer logic downstream uses this pulse.

Top module: `desc_chain_walker`

## Requirements
- R1: When the channel is idle, a head-register write with a nonzero address starts a walk. From the next cycle `chan_busy` is high and `hp_rdata` returns that address.
- R2: A descriptor at word address A holds the link at A+0, the buffer pointer at A+1, the length at A+2 and the flags at A+3. While `buf_req` is high, `buf_addr`, `buf_len`, `buf_sop` (flags bit 0) and `buf_eop` (flags bit 1) show that descriptor's contents, and they hold steady until `buf_done`.
- R3: In the write-back of a completed descriptor, the end-of-chain bit (flags bit 3) is 1 exactly when that descriptor has end-of-packet set and its link word reads zero. Otherwise the bit is 0.
- R4: The link word is read from memory after `buf_done`. A link patched while the buffer is in flight is followed.
- R5: A zero link ends the walk after that descriptor. `chan_busy` falls on the cycle after its completion pulse.
- R6: A head-register write while the channel is busy is ignored, and it sets `proto_err`, which stays set until reset.
- R7: The write-back clears the ownership bit (flags bit 2) and keeps every flags bit other than bits 2 and 3 unchanged.
- R8: After a walk has ended with the end-of-chain bit set, a new head-register write restarts the walk at the new address.
- R9: Each completed descriptor gives a single-cycle `cmpl_pulse` with `cmpl_addr` equal to its address. The pulse coincides with the flags write to A+3.
- R10: `hp_rdata` reads zero while idle and reads the current descriptor address while busy.
- R11: A head-register write of zero while idle starts nothing and does not set `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hp_we | input | 1 | Head register write strobe |
| hp_wdata | input | ADDR_W | Head register write data (descriptor address) |
| hp_rdata | output | ADDR_W | Head register read value |
| chan_busy | output | 1 | Channel is walking a chain |
| proto_err | output | 1 | Sticky: head written while busy |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |
| buf_req | output | 1 | Buffer transfer requested |
| buf_addr | output | DATA_W | Buffer pointer of current descriptor |
| buf_len | output | DATA_W | Length of current descriptor |
| buf_sop | output | 1 | Current descriptor starts a packet |
| buf_eop | output | 1 | Current descriptor ends a packet |
| buf_done | input | 1 | Buffer transfer finished |
| cmpl_pulse | output | 1 | One-cycle completion strobe |
| cmpl_addr | output | ADDR_W | Address of the completed descriptor |

## Verification
The bench aims at the late-append race in two forms. In the first, the link is patched while the buffer is in flight, and a walker that cached the link at fetch time would stop early. In the second, the patch lands after the end of the chain, so the end-of-chain bit must be set and the walk must resume only after a fresh head write. It also covers an end-of-packet descriptor whose link is nonzero, a tail descriptor without end-of-packet, and a stale end-of-chain bit left in memory. A design that got any of these wrong would mark the wrong descriptor. A head write of zero, and a head write that lands mid-walk, check that the walk neither starts spuriously nor gets redirected.

// File: rtl/dcw_pkg.sv
`timescale 1ns/1ps
package dcw_pkg;

   // word offsets inside one descriptor
   localparam int OFS_NEXT = 0;
   localparam int OFS_BUF  = 1;
   localparam int OFS_LEN  = 2;
   localparam int OFS_FLG  = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_BUF,
      ST_RD_LEN,
      ST_RD_FLG,
      ST_GET_FLG,
      ST_XFER,
      ST_RD_NXT,
      ST_WB
   } walk_st_e;

endpackage

// File: rtl/dcw_flag_merge.sv
`timescale 1ns/1ps
module dcw_flag_merge #(
   parameter int DATA_W  = 32,
   parameter int EOP_BIT = 1,
   parameter int OWN_BIT = 2,
   parameter int EOQ_BIT = 3
) (
   input  logic [DATA_W-1:0] flags_in,
   input  logic              tail_null,
   output logic [DATA_W-1:0] flags_out
);

   localparam logic [DATA_W-1:0] OWN_M  = DATA_W'(1) << OWN_BIT;
   localparam logic [DATA_W-1:0] EOQ_M  = DATA_W'(1) << EOQ_BIT;
   localparam logic [DATA_W-1:0] KEEP_M = ~(OWN_M | EOQ_M);

   logic mark_eoq;

   // end-of-chain only on a packet's last descriptor whose link is null
   assign mark_eoq  = flags_in[EOP_BIT] & tail_null;
   assign flags_out = (flags_in & KEEP_M) | (mark_eoq ? EOQ_M : '0);

endmodule

// File: rtl/dcw_head_ctl.sv
`timescale 1ns/1ps
module dcw_head_ctl #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hp_we,
   input  logic [ADDR_W-1:0] hp_wdata,
   input  logic              busy,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              start,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] hp_rdata,
   output logic              proto_err
);

   assign start      = hp_we && !busy && (hp_wdata != '0);
   assign start_addr = hp_wdata;
   assign hp_rdata   = busy ? cur_addr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             proto_err <= 1'b0;
      else if (hp_we && busy) proto_err <= 1'b1;
   end

   AST_START_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      hp_we && !busy && (hp_wdata != '0) |=> busy && (cur_addr == $past(hp_wdata))); // R1

   AST_ZERO_HEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      hp_we && !busy && (hp_wdata == '0) && !proto_err |=> !busy && !proto_err); // R11

   AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      hp_we && busy |=> proto_err); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R6

endmodule

// File: rtl/dcw_walk_fsm.sv
`timescale 1ns/1ps
module dcw_walk_fsm
   import dcw_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int SOP_BIT = 0,
   parameter int EOP_BIT = 1,
   parameter int OWN_BIT = 2,
   parameter int EOQ_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              buf_req,
   output logic [DATA_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_len,
   output logic              buf_sop,
   output logic              buf_eop,
   input  logic              buf_done,
   output logic              cmpl_pulse,
   output logic [ADDR_W-1:0] cmpl_addr
);

   localparam logic [ADDR_W-1:0] A_NEXT = ADDR_W'(OFS_NEXT);
   localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(OFS_BUF);
   localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(OFS_LEN);
   localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(OFS_FLG);

   walk_st_e          st_q, st_d;
   logic [ADDR_W-1:0] cur_q;
   logic [DATA_W-1:0] bptr_q, blen_q, flg_q;
   logic [DATA_W-1:0] flg_wb;
   logic              nxt_null;

   // in ST_WB the read data is the freshly re-read link word
   assign nxt_null = (mem_rdata == '0);

   dcw_flag_merge #(
      .DATA_W (DATA_W),
      .EOP_BIT(EOP_BIT),
      .OWN_BIT(OWN_BIT),
      .EOQ_BIT(EOQ_BIT)
   ) i_merge (
      .flags_in (flg_q),
      .tail_null(nxt_null),
      .flags_out(flg_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cur_q  <= '0;
         bptr_q <= '0;
         blen_q <= '0;
         flg_q  <= '0;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            ST_IDLE:    if (start) cur_q <= start_addr;
            ST_RD_LEN:  bptr_q <= mem_rdata;
            ST_RD_FLG:  blen_q <= mem_rdata;
            ST_GET_FLG: flg_q  <= mem_rdata;
            ST_WB:      if (!nxt_null) cur_q <= mem_rdata[ADDR_W-1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      st_d       = st_q;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = cur_q;
      mem_wdata  = '0;
      buf_req    = 1'b0;
      cmpl_pulse = 1'b0;
      unique case (st_q)
         ST_IDLE:    if (start) st_d = ST_RD_BUF;
         ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + A_BUF; st_d = ST_RD_LEN; end
         ST_RD_LEN:  begin mem_req = 1'b1; mem_addr = cur_q + A_LEN; st_d = ST_RD_FLG; end
         ST_RD_FLG:  begin mem_req = 1'b1; mem_addr = cur_q + A_FLG; st_d = ST_GET_FLG; end
         ST_GET_FLG: st_d = ST_XFER;
         ST_XFER: begin
            buf_req = 1'b1;
            if (buf_done) st_d = ST_RD_NXT;
         end
         ST_RD_NXT:  begin mem_req = 1'b1; mem_addr = cur_q + A_NEXT; st_d = ST_WB; end
         ST_WB: begin
            mem_req    = 1'b1;
            mem_we     = 1'b1;
            mem_addr   = cur_q + A_FLG;
            mem_wdata  = flg_wb;
            cmpl_pulse = 1'b1;
            st_d       = nxt_null ? ST_IDLE : ST_RD_BUF;
         end
         default:    st_d = ST_IDLE;
      endcase
   end

   assign busy      = (st_q != ST_IDLE);
   assign cur_addr  = cur_q;
   assign cmpl_addr = cur_q;
   assign buf_addr  = bptr_q;
   assign buf_len   = blen_q;
   assign buf_sop   = flg_q[SOP_BIT];
   assign buf_eop   = flg_q[EOP_BIT];

   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      buf_req && !buf_done |=> buf_req && $stable(buf_addr) && $stable(buf_len)); // R2

   AST_LINK_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse |-> $past(mem_req && !mem_we && (mem_addr == cmpl_addr))); // R4

   AST_EOQ_NULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && mem_wdata[EOQ_BIT] |-> (mem_rdata == '0)); // R3

   AST_OWN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[OWN_BIT]); // R7

   AST_CMPL_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse |-> mem_we && (mem_addr == cmpl_addr + A_FLG)); // R9

   AST_CMPL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse |=> !cmpl_pulse); // R9

   AST_STOP_ON_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse && (mem_rdata == '0) |=> !busy); // R5

endmodule

// File: rtl/desc_chain_walker.sv
`timescale 1ns/1ps
module desc_chain_walker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int SOP_BIT = 0,
   parameter int EOP_BIT = 1,
   parameter int OWN_BIT = 2,
   parameter int EOQ_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hp_we,
   input  logic [ADDR_W-1:0] hp_wdata,
   output logic [ADDR_W-1:0] hp_rdata,
   output logic              chan_busy,
   output logic              proto_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              buf_req,
   output logic [DATA_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_len,
   output logic              buf_sop,
   output logic              buf_eop,
   input  logic              buf_done,
   output logic              cmpl_pulse,
   output logic [ADDR_W-1:0] cmpl_addr
);

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= DATA_W)
         else $error("ADDR_W must lie between 2 and DATA_W");
      assert (SOP_BIT < DATA_W && EOP_BIT < DATA_W && OWN_BIT < DATA_W && EOQ_BIT < DATA_W)
         else $error("flag bit positions must fit in DATA_W");
      assert (SOP_BIT != EOP_BIT && SOP_BIT != OWN_BIT && SOP_BIT != EOQ_BIT &&
              EOP_BIT != OWN_BIT && EOP_BIT != EOQ_BIT && OWN_BIT != EOQ_BIT)
         else $error("flag bit positions must be distinct");
   end

   logic              busy;
   logic [ADDR_W-1:0] cur_addr;
   logic              start;
   logic [ADDR_W-1:0] start_addr;

   dcw_head_ctl #(.ADDR_W(ADDR_W)) i_head (
      .clk       (clk),
      .rst_n     (rst_n),
      .hp_we     (hp_we),
      .hp_wdata  (hp_wdata),
      .busy      (busy),
      .cur_addr  (cur_addr),
      .start     (start),
      .start_addr(start_addr),
      .hp_rdata  (hp_rdata),
      .proto_err (proto_err)
   );

   dcw_walk_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SOP_BIT(SOP_BIT),
      .EOP_BIT(EOP_BIT),
      .OWN_BIT(OWN_BIT),
      .EOQ_BIT(EOQ_BIT)
   ) i_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_addr(start_addr),
      .busy      (busy),
      .cur_addr  (cur_addr),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .buf_req   (buf_req),
      .buf_addr  (buf_addr),
      .buf_len   (buf_len),
      .buf_sop   (buf_sop),
      .buf_eop   (buf_eop),
      .buf_done  (buf_done),
      .cmpl_pulse(cmpl_pulse),
      .cmpl_addr (cmpl_addr)
   );

   assign chan_busy = busy;

endmodule

// File: tb/test_desc_chain_walker.sv
`timescale 1ns/1ps
module test_desc_chain_walker;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hp_we;
   logic [AW-1:0] hp_wdata;
   logic [AW-1:0] hp_rdata;
   logic          chan_busy, proto_err;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          buf_req, buf_sop, buf_eop, buf_done;
   logic [DW-1:0] buf_addr, buf_len;
   logic          cmpl_pulse;
   logic [AW-1:0] cmpl_addr;

   always #2.5 clk = ~clk;

   desc_chain_walker i_desc_chain_walker (
      .clk(clk), .rst_n(rst_n), .hp_we(hp_we), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
      .chan_busy(chan_busy), .proto_err(proto_err), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_req(buf_req),
      .buf_addr(buf_addr), .buf_len(buf_len), .buf_sop(buf_sop), .buf_eop(buf_eop),
      .buf_done(buf_done), .cmpl_pulse(cmpl_pulse), .cmpl_addr(cmpl_addr)
   );

   // behavioural memory, one-cycle read latency
   logic [DW-1:0] mem [0:255];
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   int n_chk = 0, n_fail = 0, n_cmpl = 0, xfer_delay = 2, bd_cnt = 0;
   bit run_mon = 0;

   // reference model
   bit            m_busy, m_err, prev_cmpl;
   logic [AW-1:0] m_cur;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // buffer-done responder
   initial begin
      buf_done = 1'b0;
      forever begin
         @(posedge clk); #1;
         if (buf_done) buf_done = 1'b0;
         else if (buf_req) begin
            if (bd_cnt >= xfer_delay) begin buf_done = 1'b1; bd_cnt = 0; end
            else bd_cnt++;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && run_mon) begin
         bit            busy_pre;
         logic [DW-1:0] f_org, f_exp, nxt;
         bit            eoq;
         busy_pre = m_busy;
         chk(chan_busy == m_busy, "R1/R5 busy", chan_busy, m_busy);
         chk(hp_rdata == (m_busy ? m_cur : '0), "R10 readback", hp_rdata, m_busy ? m_cur : 0);
         chk(proto_err == m_err, "R6 proto_err", proto_err, m_err);
         if (prev_cmpl) chk(!cmpl_pulse, "R9 single pulse", cmpl_pulse, 0);
         if (buf_req) begin
            chk(buf_addr == mem[m_cur[7:0] + 1], "R2 buf_addr", buf_addr, mem[m_cur[7:0] + 1]);
            chk(buf_len == mem[m_cur[7:0] + 2], "R2 buf_len", buf_len, mem[m_cur[7:0] + 2]);
            chk({buf_eop, buf_sop} == mem[m_cur[7:0] + 3][1:0], "R2 sop/eop",
                {buf_eop, buf_sop}, mem[m_cur[7:0] + 3][1:0]);
         end
         if (cmpl_pulse) begin
            n_cmpl++;
            nxt   = mem[m_cur[7:0]];
            f_org = mem[m_cur[7:0] + 3];
            eoq   = f_org[1] && (nxt == 0);
            f_exp = (f_org & ~32'hC) | (eoq ? 32'h8 : 32'h0);
            chk(cmpl_addr == m_cur, "R9 cmpl_addr", cmpl_addr, m_cur);
            chk(mem_we && mem_addr == m_cur + 3, "R9 write-back address", mem_addr, m_cur + 3);
            chk(mem_wdata[3] == eoq, "R3 end-of-chain bit", mem_wdata[3], eoq);
            chk(mem_wdata == f_exp, "R7 flags write-back", mem_wdata, f_exp);
            if (nxt == 0) m_busy = 0;
            else m_cur = nxt[AW-1:0];
         end
         if (hp_we) begin
            if (busy_pre) m_err = 1;
            else if (hp_wdata != 0) begin m_busy = 1; m_cur = hp_wdata; end
         end
         prev_cmpl = cmpl_pulse;
      end
   end

   task automatic setd(input int a, input int nxt, input int bp, input int ln, input int fl);
      mem[a] = nxt; mem[a+1] = bp; mem[a+2] = ln; mem[a+3] = fl;
   endtask

   task automatic head(input int a);
      @(posedge clk); #1;
      hp_we = 1'b1; hp_wdata = AW'(a);
      @(posedge clk); #1;
      hp_we = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (chan_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_xfer(input int a);
      @(negedge clk);
      while (!(buf_req && hp_rdata == AW'(a))) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int c0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      rst_n = 1'b0; hp_we = 1'b0; hp_wdata = '0;
      m_busy = 0; m_err = 0; m_cur = '0; prev_cmpl = 0;
      repeat (3) @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!chan_busy && hp_rdata == 0, "R10 reset idle", hp_rdata, 0);
      chk(!proto_err && !cmpl_pulse && !mem_req && !buf_req, "R6 reset outputs",
          {proto_err, cmpl_pulse, mem_req, buf_req}, 0);
      run_mon = 1;

      // single descriptor packet with a user bit, null link
      setd(16, 0, 'h1000, 64, 'h107);
      c0 = n_cmpl; head(16); wait_idle();
      chk(mem[19] == 'h10B, "R3 R7 single packet flags", mem[19], 'h10B);
      chk(n_cmpl - c0 == 1, "R5 one completion", n_cmpl - c0, 1);

      // three-descriptor packet, stale end-of-chain bit in the first
      setd(32, 36, 'h2000, 10, 'hD);
      setd(36, 40, 'h2100, 11, 'h4);
      setd(40, 0,  'h2200, 12, 'h6);
      c0 = n_cmpl; head(32); wait_idle();
      chk(mem[35] == 'h1, "R3 stale bit cleared", mem[35], 'h1);
      chk(mem[39] == 'h0, "R7 middle flags", mem[39], 'h0);
      chk(mem[43] == 'hA, "R3 tail flags", mem[43], 'hA);
      chk(n_cmpl - c0 == 3, "R5 chain length", n_cmpl - c0, 3);

      // end-of-packet with a nonzero link gets no marker
      setd(48, 52, 'h3000, 5, 'h7);
      setd(52, 0,  'h3100, 6, 'h7);
      head(48); wait_idle();
      chk(mem[51] == 'h3, "R3 eop with link", mem[51], 'h3);
      chk(mem[55] == 'hB, "R3 eop null link", mem[55], 'hB);

      // tail without end-of-packet: walk stops, no marker
      setd(60, 0, 'h3200, 7, 'h5);
      c0 = n_cmpl; head(60); wait_idle();
      chk(mem[63] == 'h1, "R3 R5 non-eop tail", mem[63], 'h1);
      chk(n_cmpl - c0 == 1, "R5 stop on null", n_cmpl - c0, 1);

      // zero head write while idle
      head(0); repeat (4) @(negedge clk);
      chk(!chan_busy && !proto_err && hp_rdata == 0, "R11 zero head ignored",
          {chan_busy, proto_err}, 0);

      // link patched while buffer in flight
      xfer_delay = 6;
      setd(68, 0, 'h4000, 8, 'h7);
      setd(72, 0, 'h4100, 9, 'h7);
      c0 = n_cmpl; head(68); wait_xfer(68);
      mem[68] = 72;
      wait_idle();
      chk(n_cmpl - c0 == 2, "R4 patched link followed", n_cmpl - c0, 2);
      chk(mem[71] == 'h3 && mem[75] == 'hB, "R4 patched flags", {mem[71][7:0], mem[75][7:0]}, 'h030B);

      // patch too late: marker set, restart with head write
      xfer_delay = 1;
      setd(76, 0, 'h5000, 4, 'h7);
      setd(80, 0, 'h5100, 4, 'h7);
      head(76); wait_idle();
      mem[76] = 80;
      chk(mem[79][3] == 1'b1, "R8 marker seen", mem[79][3], 1);
      chk(!chan_busy, "R8 stopped before restart", chan_busy, 0);
      c0 = n_cmpl; head(80); wait_idle();
      chk(n_cmpl - c0 == 1 && mem[83] == 'hB, "R8 restart walks new chain", mem[83], 'hB);

      // head write during a walk is ignored and flags an error
      xfer_delay = 8;
      setd(88, 0, 'h6000, 3, 'h7);
      setd(100, 0, 'h6100, 3, 'h7);
      c0 = n_cmpl; head(88); wait_xfer(88);
      head(100); wait_idle();
      chk(proto_err, "R6 error raised", proto_err, 1);
      chk(mem[103] == 'h7 && n_cmpl - c0 == 1, "R6 write ignored", mem[103], 'h7);
      repeat (5) @(negedge clk);
      chk(proto_err, "R6 error sticky", proto_err, 1);

      run_mon = 0;
      summary();
   end

endmodule